// File: doc/BRIEF.md
# Charging Port Detection Handshake Controller

This block runs the digital half of the charge-detection handshake on a hub's downstream ports. Each port has one handshake engine. While a port is enabled as a charging port and a device is attached, the engine watches a comparator flag. The flag shows whether the device is driving its own voltage source on D+. The flag first passes through a two-flop synchronizer and a programmable debounce filter.

When the filtered flag goes high, the engine turns on the port's D- voltage source as its answer. It holds that source on and counts how many cycles the device keeps D+ driven. When the device releases D+, the engine compares the measured on-time with a programmable acceptance window. It then either reports a completed negotiation or reports a failure and falls back to idle. Once negotiation has completed, the engine reports the current class the device may draw, which depends on the device's signalling speed.

A shared configuration input sets how many of the ports act as charging ports; ports beyond that count stay idle. Every input and output is a plain level signal, and no stream interface exists.

Top module: `chgdet_top`

## Requirements
- R1: After reset, every port reports status 00 (idle), every D- source enable is low and every current class is 00.
- R2: The D+ detect input is synchronized by two flops, and its filtered value changes only after the synchronized value has differed from it for `cfg_db_len` consecutive cycles (a length of 0 acts as 1). A raw pulse shorter than `cfg_db_len` cycles is ignored.
- R3: If the raw D+ detect rises and is first sampled high at clock edge 1, the port's D- source enable goes high right after edge `cfg_db_len`+3 and not earlier. Status is 01 (responding) while the source is held.
- R4: If the device holds D+ for H cycles with `cfg_on_min` <= H <= `cfg_on_max`, the port enters status 10 (negotiated) once D+ is released, with the D- source off. It stays there while the port remains active.
- R5: If H < `cfg_on_min`, the port shows status 11 (failed) after the release and then returns to 00 without passing through status 10.
- R6: Once the on-time exceeds `cfg_on_max` with D+ still driven, the port shows status 11 with the D- source off. It returns to 00 after D+ is released, and it never reports success for that attempt.
- R7: In status 10 the current class is 01 (900 mA) when the device's high-speed flag is set, and 10 (1.5 A) otherwise. In every other status the class is 00.
- R8: Dropping `chg_enable` or the port's attach flag turns off that port's D- source in the same cycle, and the port reports status 00 after the next clock edge.
- R9: Port i acts as a charging port only when i < `cfg_nports`. Other ports stay at status 00 with the D- source off, whatever their inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chg_enable | input | 1 | Global enable for charging-port detection |
| cfg_nports | input | NP_W | Number of ports acting as charging ports (lowest indices first) |
| cfg_db_len | input | CNT_W | Debounce length in cycles |
| cfg_on_min | input | CNT_W | Minimum accepted D+ on-time in cycles |
| cfg_on_max | input | CNT_W | Maximum accepted D+ on-time in cycles |
| dev_attached | input | N_PORTS | Per-port device-attached flag |
| dp_src_seen | input | N_PORTS | Per-port raw comparator flag: device drives D+ source |
| dev_hs | input | N_PORTS | Per-port flag: device signals at high speed |
| dm_src_en | output | N_PORTS | Per-port enable of the D- response source |
| port_status | output | 2*N_PORTS | Per-port status, 2 bits per port (00 idle, 01 responding, 10 negotiated, 11 failed) |
| cur_class | output | 2*N_PORTS | Per-port current class (00 default, 01 900 mA, 10 1.5 A) |

## Verification
The on-time is swept across and past both edges of two different acceptance windows, once for each speed flag. Success at exactly the minimum and maximum, and failure one cycle outside either edge, separate an off-by-one in the timer from a correct window compare. Pulses one cycle shorter than the debounce length and exactly equal to it, together with response-latency checks for several debounce lengths, pin down the filter and synchronizer depth. Mid-response drops of enable and of attach, plus a sweep of the charging-port count with all ports stimulated at once, show the abort path and the port selection.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RESP = 2'b01,
    ST_DONE = 2'b10,
    ST_FAIL = 2'b11
  } hs_state_e;

  typedef enum logic [1:0] {
    CLS_DEF  = 2'b00,
    CLS_900  = 2'b01,
    CLS_1500 = 2'b10
  } cur_class_e;

endpackage

// File: rtl/chgdet_filter.sv
module chgdet_filter #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_in,
  input  logic [CNT_W-1:0] db_len,
  output logic             filt_out
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic [CNT_W-1:0]       run_cnt;
  logic [CNT_W-1:0]       limit;

  // synchronizer chain, oldest sample at the top bit
  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
  end

  assign synced = sync_q[SYNC_STAGES-1];

  // a zero length behaves as one cycle
  assign limit = (db_len == '0) ? '0 : db_len - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      filt_out <= 1'b0;
    end else if (synced == filt_out) begin
      run_cnt <= '0;
    end else if (run_cnt >= limit) begin
      filt_out <= synced;
      run_cnt  <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/chgdet_port.sv
module chgdet_port
  import chgdet_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             det,
  input  logic             dev_hs,
  input  logic [CNT_W-1:0] on_min,
  input  logic [CNT_W-1:0] on_max,
  output logic             dm_src,
  output logic [1:0]       status,
  output logic [1:0]       cls
);

  hs_state_e        state_q, state_d;
  logic [CNT_W-1:0] tmr_q, tmr_d;
  logic             in_window;

  assign in_window = (tmr_q >= on_min) && (tmr_q <= on_max);

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    if (!active) begin
      state_d = ST_IDLE;
      tmr_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (det) begin
            state_d = ST_RESP;
            tmr_d   = {{(CNT_W-1){1'b0}}, 1'b1};
          end
        end
        ST_RESP: begin
          if (det) begin
            if (tmr_q >= on_max) state_d = ST_FAIL;
            else                 tmr_d   = tmr_q + 1'b1;
          end else begin
            state_d = in_window ? ST_DONE : ST_FAIL;
          end
        end
        ST_DONE: state_d = ST_DONE;
        ST_FAIL: begin
          if (!det) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  // the response source is gated by activity so an abort turns it off at once
  assign dm_src = (state_q == ST_RESP) && active;
  assign status = state_q;

  always_comb begin
    if (state_q == ST_DONE) cls = dev_hs ? CLS_900 : CLS_1500;
    else                    cls = CLS_DEF;
  end

endmodule

// File: rtl/chgdet_top.sv
module chgdet_top #(
  parameter  int N_PORTS = 3,
  parameter  int CNT_W   = 8,
  localparam int NP_W    = $clog2(N_PORTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chg_enable,
  input  logic [NP_W-1:0]      cfg_nports,
  input  logic [CNT_W-1:0]     cfg_db_len,
  input  logic [CNT_W-1:0]     cfg_on_min,
  input  logic [CNT_W-1:0]     cfg_on_max,
  input  logic [N_PORTS-1:0]   dev_attached,
  input  logic [N_PORTS-1:0]   dp_src_seen,
  input  logic [N_PORTS-1:0]   dev_hs,
  output logic [N_PORTS-1:0]   dm_src_en,
  output logic [2*N_PORTS-1:0] port_status,
  output logic [2*N_PORTS-1:0] cur_class
);

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    logic det_f;
    logic act;

    assign act = chg_enable && dev_attached[i] && (NP_W'(i) < cfg_nports);

    chgdet_filter #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (dp_src_seen[i]),
      .db_len   (cfg_db_len),
      .filt_out (det_f)
    );

    chgdet_port #(.CNT_W(CNT_W)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (act),
      .det    (det_f),
      .dev_hs (dev_hs[i]),
      .on_min (cfg_on_min),
      .on_max (cfg_on_max),
      .dm_src (dm_src_en[i]),
      .status (port_status[2*i +: 2]),
      .cls    (cur_class[2*i +: 2])
    );
  end

endmodule

// File: rtl/chgdet_chk.sv
module chgdet_chk #(
  parameter  int N_PORTS = 3,
  localparam int NP_W    = $clog2(N_PORTS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 chg_enable,
  input logic [NP_W-1:0]      cfg_nports,
  input logic [N_PORTS-1:0]   dev_attached,
  input logic [N_PORTS-1:0]   dm_src_en,
  input logic [2*N_PORTS-1:0] port_status,
  input logic [2*N_PORTS-1:0] cur_class
);

  p_inactive_dm_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_enable |-> (dm_src_en == '0));

  for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
    p_detach_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_attached[i] |=> (port_status[2*i +: 2] == 2'b00));

    p_class_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_class[2*i +: 2] != 2'b00) |-> (port_status[2*i +: 2] == 2'b10));

    p_unused_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (i >= int'(cfg_nports)) |-> !dm_src_en[i]);

    p_resp_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dm_src_en[i]) |-> ($past(port_status[2*i +: 2]) == 2'b00));

    p_done_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((port_status[2*i +: 2] == 2'b10) && ($past(port_status[2*i +: 2]) != 2'b10))
      |-> ($past(port_status[2*i +: 2]) == 2'b01));
  end

endmodule

bind chgdet_top chgdet_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chg_enable   (chg_enable),
  .cfg_nports   (cfg_nports),
  .dev_attached (dev_attached),
  .dm_src_en    (dm_src_en),
  .port_status  (port_status),
  .cur_class    (cur_class)
);

// File: tb/sim_chgdet_top.sv
module sim_chgdet_top;

  localparam int NP = 3;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chg_enable = 1'b0;
  logic [1:0]    cfg_nports = 2'd3;
  logic [CW-1:0] cfg_db_len = 8'd2;
  logic [CW-1:0] cfg_on_min = 8'd4;
  logic [CW-1:0] cfg_on_max = 8'd8;
  logic [NP-1:0] dev_attached = '0;
  logic [NP-1:0] dp_src_seen = '0;
  logic [NP-1:0] dev_hs = '0;
  logic [NP-1:0]   dm_src_en;
  logic [2*NP-1:0] port_status;
  logic [2*NP-1:0] cur_class;

  int n_chk = 0;
  int n_bad = 0;
  logic [NP-1:0] seen_fail = '0;
  logic [NP-1:0] seen_dm = '0;
  logic [NP-1:0] seen_done = '0;

  always #2 clk = ~clk;

  chgdet_top #(.N_PORTS(NP), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .chg_enable(chg_enable), .cfg_nports(cfg_nports),
    .cfg_db_len(cfg_db_len), .cfg_on_min(cfg_on_min), .cfg_on_max(cfg_on_max),
    .dev_attached(dev_attached), .dp_src_seen(dp_src_seen), .dev_hs(dev_hs),
    .dm_src_en(dm_src_en), .port_status(port_status), .cur_class(cur_class)
  );

  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (port_status[2*p +: 2] == 2'b11) seen_fail[p] = 1'b1;
      if (port_status[2*p +: 2] == 2'b10) seen_done[p] = 1'b1;
      if (dm_src_en[p]) seen_dm[p] = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic int st(input int p);
    return int'(port_status[2*p +: 2]);
  endfunction

  function automatic int cls(input int p);
    return int'(cur_class[2*p +: 2]);
  endfunction

  task automatic clear_port(input int p);
    @(negedge clk);
    dp_src_seen[p] = 1'b0;
    dev_attached[p] = 1'b0;
    repeat (int'(cfg_db_len) + 4) @(negedge clk);
    dev_attached[p] = 1'b1;
    seen_fail[p] = 1'b0;
    seen_dm[p] = 1'b0;
    seen_done[p] = 1'b0;
  endtask

  // one handshake attempt of h cycles on port p, outcome computed from the window
  task automatic trial(input int p, input int h, input bit hs);
    bit good;
    int exp_cls;
    good = (h >= int'(cfg_on_min)) && (h <= int'(cfg_on_max));
    exp_cls = good ? (hs ? 1 : 2) : 0;
    dev_hs[p] = hs;
    @(negedge clk);
    dp_src_seen[p] = 1'b1;
    repeat (h) @(negedge clk);
    dp_src_seen[p] = 1'b0;
    repeat (int'(cfg_db_len) + 6) @(negedge clk);
    if (good) begin
      check(st(p) == 2 && !seen_fail[p], "R4 in-window on-time negotiated", st(p), 2);
    end else if (h < int'(cfg_on_min)) begin
      check(st(p) == 0 && seen_fail[p] && !seen_done[p], "R5 short on-time fails", st(p), 0);
    end else begin
      check(st(p) == 0 && seen_fail[p] && !seen_done[p], "R6 long on-time fails", st(p), 0);
    end
    check(cls(p) == exp_cls, "R7 current class", cls(p), exp_cls);
    check(dm_src_en[p] == 1'b0, "R4 source off after attempt", int'(dm_src_en[p]), 0);
    clear_port(p);
  endtask

  initial begin
    #(4 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(port_status == '0, "R1 reset status", int'(port_status), 0);
    check(dm_src_en == '0, "R1 reset source", int'(dm_src_en), 0);
    check(cur_class == '0, "R1 reset class", int'(cur_class), 0);
    rst_n = 1'b1;
    chg_enable = 1'b1;
    dev_attached = '1;
    repeat (2) @(negedge clk);

    // window sweep, first configuration
    cfg_db_len = 8'd2; cfg_on_min = 8'd4; cfg_on_max = 8'd8;
    for (int hs = 0; hs < 2; hs++)
      for (int h = 2; h <= 10; h++) trial(0, h, hs[0]);

    // window sweep, second configuration on another port
    cfg_db_len = 8'd1; cfg_on_min = 8'd1; cfg_on_max = 8'd3;
    for (int hs = 0; hs < 2; hs++)
      for (int h = 1; h <= 5; h++) trial(1, h, hs[0]);

    // R3 response latency for several debounce lengths
    cfg_on_min = 8'd1; cfg_on_max = 8'd200;
    for (int db = 1; db <= 4; db++) begin
      cfg_db_len = CW'(db);
      clear_port(2);
      dp_src_seen[2] = 1'b1;
      repeat (db + 2) @(posedge clk);
      @(negedge clk);
      check(dm_src_en[2] == 1'b0, "R3 source not yet on", int'(dm_src_en[2]), 0);
      @(posedge clk);
      @(negedge clk);
      check(dm_src_en[2] == 1'b1 && st(2) == 1, "R3 source on responding", int'(dm_src_en[2]), 1);
      clear_port(2);
    end

    // R2 glitch rejection and boundary
    cfg_db_len = 8'd4;
    clear_port(0);
    dp_src_seen[0] = 1'b1;
    repeat (3) @(negedge clk);
    dp_src_seen[0] = 1'b0;
    repeat (12) @(negedge clk);
    check(!seen_dm[0] && st(0) == 0, "R2 short pulse ignored", int'(seen_dm[0]), 0);
    dp_src_seen[0] = 1'b1;
    repeat (4) @(negedge clk);
    dp_src_seen[0] = 1'b0;
    repeat (12) @(negedge clk);
    check(seen_dm[0] == 1'b1, "R2 pulse of debounce length accepted", int'(seen_dm[0]), 1);
    clear_port(0);

    // R8 enable drop mid-response
    cfg_db_len = 8'd1;
    dp_src_seen[0] = 1'b1;
    repeat (6) @(negedge clk);
    check(dm_src_en[0] == 1'b1, "R8 responding before abort", int'(dm_src_en[0]), 1);
    chg_enable = 1'b0;
    #1;
    check(dm_src_en[0] == 1'b0, "R8 enable drop source off same cycle", int'(dm_src_en[0]), 0);
    @(negedge clk);
    check(st(0) == 0, "R8 enable drop idle", st(0), 0);
    dp_src_seen[0] = 1'b0;
    repeat (6) @(negedge clk);
    chg_enable = 1'b1;
    clear_port(0);

    // R8 detach mid-response
    dp_src_seen[1] = 1'b1;
    repeat (6) @(negedge clk);
    dev_attached[1] = 1'b0;
    #1;
    check(dm_src_en[1] == 1'b0, "R8 detach source off same cycle", int'(dm_src_en[1]), 0);
    @(negedge clk);
    check(st(1) == 0, "R8 detach idle", st(1), 0);
    clear_port(1);

    // R9 charging-port count
    for (int n = 0; n <= 3; n++) begin
      cfg_nports = 2'(n);
      dp_src_seen = '1;
      repeat (7) @(negedge clk);
      check(dm_src_en == NP'((1 << n) - 1), "R9 ports responding by count",
            int'(dm_src_en), (1 << n) - 1);
      for (int p = n; p < NP; p++)
        check(st(p) == 0, "R9 unused port idle", st(p), 0);
      for (int p = 0; p < NP; p++) clear_port(p);
    end

    finish_run();
  end

endmodule